// File: doc/BRIEF.md
# Priority-Slotted Broadcast Reply Arbiter

This block sits between one node and a shared broadcast medium. When a query frame such as "who is free?" finishes on the medium, every node opens the same reply window. The window is split into one slot per priority level, and the highest priority owns the earliest slot. A node that wants to answer does so only inside its own slot. Any reply that the node hears on the medium before its own slot begins cancels its pending answer. As a result, the first reply that appears comes from the most urgent idle node, and every lower-priority reply is held back at the interface. The local node gets a one-cycle accept pulse when its reply has gone out. It gets a one-cycle reject pulse when its reply was blocked, too late, or asked for while no window was open. Requests are never queued.

The same block sends the node's own queries. It opens the window locally after its own query and reports, when that window closes, whether any reply was heard. A jam guard keeps one node from flooding the medium. After the node's own transmission ends, a new transmission waits for a fixed number of idle cycles, unless a complete frame from another node has been received in the meantime.

Top module: `bcast_reply_arb`

## Requirements
- R1: While reset is held and right after it is released, `bus_tx_en`, `rep_ok`, `rep_rej` and `qry_done` are low.
- R2: A query frame received from the medium opens a window of NUM_PRIO*SLOT_CYC cycles. Window cycle k lies in slot k/SLOT_CYC. A node of priority p owns slot NUM_PRIO-1-p, so priority NUM_PRIO-1 owns slot 0. An accepted reply drives `bus_tx_en` in cycles 1 to SLOT_CYC-1 of its own slot and at no other time.
- R3: An accepted reply produces a single-cycle `rep_ok` in the first cycle after its slot ends.
- R4: If another node's carrier is sampled in the window before the local slot starts, a pending or new reply request is rejected with a single-cycle `rep_rej` in the next cycle, and no transmission takes place.
- R5: A reply request first seen after the first cycle of the node's own slot is rejected in the next cycle.
- R6: A reply request seen while no window is open is rejected in the next cycle, with no transmission.
- R7: A query request sent while the medium is idle and the guard is satisfied drives `bus_tx_en` for QRY_CYC cycles. The window then opens with no further transmission from this node. A reply request made inside the node's own query window is rejected in the next cycle.
- R8: When the window of the node's own query closes, `qry_done` pulses for one cycle. `qry_hit` is 1 if carrier was sampled at any time in that window, and 0 otherwise.
- R9: After the node's own transmission ends, no new transmission starts until GAP_CYC cycles have passed. A completed reception (`bus_rx_end`) releases the guard, and the transmission may then start one cycle later.
- R10: `rep_ok` and `rep_rej` are never high together, and each request gets exactly one answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_prio | input | $clog2(NUM_PRIO) | Priority of this node; higher value means an earlier slot |
| bus_carrier | input | 1 | Another node is transmitting on the medium |
| bus_rx_end | input | 1 | One-cycle pulse: a frame from another node has completed |
| bus_rx_query | input | 1 | Qualifies `bus_rx_end`: the completed frame was a query |
| bus_tx_en | output | 1 | This node drives the medium |
| rep_req | input | 1 | Level request to answer the current query; drop it after the answer |
| rep_ok | output | 1 | One-cycle pulse: the reply was sent and accepted |
| rep_rej | output | 1 | One-cycle pulse: the reply was refused |
| qry_req | input | 1 | Level request to send a query; drop it on `qry_done` |
| qry_done | output | 1 | One-cycle pulse: the window of the own query has closed |
| qry_hit | output | 1 | Valid with `qry_done`: a reply was heard |

## Verification
Every result is registered, so the bench counts edges from the one that samples the stimulus:
- A rejection appears one cycle after the request or carrier that caused it.
- An accepted reply starts transmitting one cycle after the window reaches the node's slot and ends exactly at the slot boundary.
- The accept pulse follows in the cycle after the slot ends.
- `qry_done` appears QRY_CYC + NUM_PRIO*SLOT_CYC cycles after the query request is taken.

The bench indexes each window cycle from the edge that opened it and predicts the answer cycle with a function. Inputs change and outputs are compared only on falling edges, and every output is compared in every window cycle, so an answer that comes a cycle early or late is caught. For the jam guard, the bench counts the idle cycles from the end of the previous query and expects the transmission to start on exactly the cycle that count allows.

// File: rtl/bri_pkg.sv
package bri_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QTX  = 2'd1,
    ST_WIN  = 2'd2
  } link_st_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_PEND = 2'd1,
    RP_SEND = 2'd2
  } rply_st_e;

endpackage

// File: rtl/bri_rst_sync.sv
module bri_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/bri_slot_timer.sv
module bri_slot_timer #(
  parameter  int NUM_SLOT = 4,
  parameter  int SLOT_CYC = 4,
  localparam int SLOT_W   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int CYC_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic              slot_end;

  assign slot_end = (cyc_q == CYC_W'(SLOT_CYC - 1));

  always_comb begin
    slot_d = slot_q;
    cyc_d  = cyc_q;
    if (clr) begin
      slot_d = '0;
      cyc_d  = '0;
    end else if (en) begin
      if (slot_end) begin
        cyc_d  = '0;
        slot_d = (slot_q == SLOT_W'(NUM_SLOT - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      cyc_q  <= '0;
    end else if (clr || en) begin
      slot_q <= slot_d;
      cyc_q  <= cyc_d;
    end
  end

  assign slot_o = slot_q;
  assign cyc_o  = cyc_q;
  assign last_o = slot_end && (slot_q == SLOT_W'(NUM_SLOT - 1));
endmodule

// File: rtl/bri_jam_guard.sv
module bri_jam_guard #(
  parameter  int GAP_CYC = 40,
  localparam int GAP_W   = $clog2(GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_end,
  input  logic rx_end,
  output logic ok_o
);
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             sat;
  logic             gap_en;

  assign sat = (gap_q == GAP_W'(GAP_CYC));

  always_comb begin
    gap_d  = gap_q;
    gap_en = 1'b0;
    if (tx_end) begin
      gap_d  = '0;
      gap_en = 1'b1;
    end else if (rx_end) begin
      gap_d  = GAP_W'(GAP_CYC);
      gap_en = 1'b1;
    end else if (!sat) begin
      gap_d  = gap_q + 1'b1;
      gap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_W'(GAP_CYC);
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  assign ok_o = sat;
endmodule

// File: rtl/bcast_reply_arb.sv
module bcast_reply_arb
  import bri_pkg::*;
#(
  parameter  int NUM_PRIO = 4,
  parameter  int SLOT_CYC = 4,
  parameter  int QRY_CYC  = 3,
  parameter  int GAP_CYC  = 40,
  localparam int PRIO_W   = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1,
  localparam int CYC_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int QCNT_W   = $clog2(QRY_CYC + 1)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [PRIO_W-1:0] node_prio,
  input  logic              bus_carrier,
  input  logic              bus_rx_end,
  input  logic              bus_rx_query,
  output logic              bus_tx_en,
  input  logic              rep_req,
  output logic              rep_ok,
  output logic              rep_rej,
  input  logic              qry_req,
  output logic              qry_done,
  output logic              qry_hit
);
  logic              srst_n;
  link_st_e          st_q, st_d;
  rply_st_e          rp_q, rp_d;
  logic              ownq_q, ownq_d;
  logic              seen_q, seen_d;
  logic [QCNT_W-1:0] qcnt_q, qcnt_d;
  logic              tx_q, tx_d;
  logic              ok_q, ok_d;
  logic              rej_q, rej_d;
  logic              done_q, done_d;
  logic              hit_q, hit_d;

  logic              tmr_clr;
  logic              in_win;
  logic              win_last;
  logic [PRIO_W-1:0] slot_w;
  logic [CYC_W-1:0]  cyc_w;
  logic [PRIO_W-1:0] own_slot;
  logic              guard_ok;
  logic              tx_end;
  logic              rx_done;
  logic              want;
  logic              slot_past;
  logic              slot_here;
  logic              slot_done;

  bri_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  bri_slot_timer #(
    .NUM_SLOT (NUM_PRIO),
    .SLOT_CYC (SLOT_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (tmr_clr),
    .en     (in_win),
    .slot_o (slot_w),
    .cyc_o  (cyc_w),
    .last_o (win_last)
  );

  bri_jam_guard #(
    .GAP_CYC (GAP_CYC)
  ) u_guard (
    .clk    (clk),
    .rst_n  (srst_n),
    .tx_end (tx_end),
    .rx_end (rx_done),
    .ok_o   (guard_ok)
  );

  assign in_win    = (st_q == ST_WIN);
  assign rx_done   = bus_rx_end;
  assign own_slot  = PRIO_W'(NUM_PRIO - 1) - node_prio;
  assign slot_here = (slot_w == own_slot) && (cyc_w == '0);
  assign slot_past = (slot_w > own_slot) || ((slot_w == own_slot) && (cyc_w != '0));
  assign slot_done = (cyc_w == CYC_W'(SLOT_CYC - 1));
  assign want      = (rp_q == RP_PEND) ||
                     ((rp_q == RP_NONE) && rep_req && !ok_q && !rej_q);

  always_comb begin
    st_d    = st_q;
    ownq_d  = ownq_q;
    seen_d  = seen_q;
    qcnt_d  = qcnt_q;
    tx_d    = tx_q;
    rp_d    = rp_q;
    ok_d    = 1'b0;
    rej_d   = 1'b0;
    done_d  = 1'b0;
    hit_d   = hit_q;
    tmr_clr = 1'b0;
    tx_end  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (bus_rx_end && bus_rx_query) begin
          st_d    = ST_WIN;
          ownq_d  = 1'b0;
          seen_d  = 1'b0;
          tmr_clr = 1'b1;
        end else if (qry_req && !bus_carrier && guard_ok) begin
          st_d   = ST_QTX;
          qcnt_d = '0;
          tx_d   = 1'b1;
        end
      end
      ST_QTX: begin
        if (qcnt_q == QCNT_W'(QRY_CYC - 1)) begin
          st_d    = ST_WIN;
          ownq_d  = 1'b1;
          seen_d  = 1'b0;
          tmr_clr = 1'b1;
          tx_d    = 1'b0;
          tx_end  = 1'b1;
        end else begin
          qcnt_d = qcnt_q + 1'b1;
        end
      end
      ST_WIN: begin
        seen_d = seen_q | bus_carrier;
        if (win_last) begin
          st_d = ST_IDLE;
          if (ownq_q) begin
            done_d = 1'b1;
            hit_d  = seen_q | bus_carrier;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (rp_q == RP_SEND) begin
      if (slot_done) begin
        rp_d   = RP_NONE;
        tx_d   = 1'b0;
        ok_d   = 1'b1;
        tx_end = 1'b1;
      end
    end else if (want) begin
      if (!in_win || ownq_q || seen_q || bus_carrier || slot_past) begin
        rp_d  = RP_NONE;
        rej_d = 1'b1;
      end else if (slot_here) begin
        if (guard_ok) begin
          rp_d = RP_SEND;
          tx_d = 1'b1;
        end else begin
          rp_d  = RP_NONE;
          rej_d = 1'b1;
        end
      end else begin
        rp_d = RP_PEND;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      rp_q   <= RP_NONE;
      ownq_q <= 1'b0;
      seen_q <= 1'b0;
      qcnt_q <= '0;
      tx_q   <= 1'b0;
      ok_q   <= 1'b0;
      rej_q  <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rp_q   <= rp_d;
      ownq_q <= ownq_d;
      seen_q <= seen_d;
      qcnt_q <= qcnt_d;
      tx_q   <= tx_d;
      ok_q   <= ok_d;
      rej_q  <= rej_d;
      done_q <= done_d;
      hit_q  <= hit_d;
    end
  end

  assign bus_tx_en = tx_q;
  assign rep_ok    = ok_q;
  assign rep_rej   = rej_q;
  assign qry_done  = done_q;
  assign qry_hit   = hit_q;
endmodule

// File: rtl/bri_chk.sv
module bri_chk #(
  parameter  int NUM_PRIO = 4,
  localparam int PRIO_W   = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              ok,
  input logic              rej,
  input logic              done,
  input logic              in_win,
  input logic [PRIO_W-1:0] slot,
  input logic [PRIO_W-1:0] own_slot,
  input logic              guard_ok,
  input logic              seen
);
  // R2
  tx_in_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && in_win) |-> (slot == own_slot));

  // R3
  ok_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> ($past(tx_en) && !tx_en));

  // R4
  no_start_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && in_win) |-> !seen);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_from_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(in_win) && !in_win));

  // R9
  guard_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(guard_ok));

  // R10
  ok_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && rej));
endmodule

bind bcast_reply_arb bri_chk #(
  .NUM_PRIO (NUM_PRIO)
) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .tx_en    (bus_tx_en),
  .ok       (rep_ok),
  .rej      (rep_rej),
  .done     (qry_done),
  .in_win   (in_win),
  .slot     (slot_w),
  .own_slot (own_slot),
  .guard_ok (guard_ok),
  .seen     (seen_q)
);

// File: tb/bcast_reply_arb_tb.sv
module bcast_reply_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int SC   = 4;
  localparam int QC   = 3;
  localparam int GC   = 40;
  localparam int WLEN = NP * SC;
  localparam int PW   = $clog2(NP);

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic [PW-1:0] node_prio = '0;
  logic          bus_carrier = 1'b0;
  logic          bus_rx_end = 1'b0;
  logic          bus_rx_query = 1'b0;
  logic          bus_tx_en;
  logic          rep_req = 1'b0;
  logic          rep_ok;
  logic          rep_rej;
  logic          qry_req = 1'b0;
  logic          qry_done;
  logic          qry_hit;

  int n_chk = 0;
  int n_fail = 0;
  int wd_cnt = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcast_reply_arb #(
    .NUM_PRIO (NP),
    .SLOT_CYC (SC),
    .QRY_CYC  (QC),
    .GAP_CYC  (GC)
  ) u_dut (
    .clk          (clk),
    .arst_n       (arst_n),
    .node_prio    (node_prio),
    .bus_carrier  (bus_carrier),
    .bus_rx_end   (bus_rx_end),
    .bus_rx_query (bus_rx_query),
    .bus_tx_en    (bus_tx_en),
    .rep_req      (rep_req),
    .rep_ok       (rep_ok),
    .rep_rej      (rep_rej),
    .qry_req      (qry_req),
    .qry_done     (qry_done),
    .qry_hit      (qry_hit)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  // Predict answer for a reply request raised at window cycle r.
  function automatic void predict(input int o, input bit comp, input int c, input int r,
                                  output bit okk, output int idx);
    okk = 1'b0;
    idx = -1;
    for (int k = r; k < WLEN; k++) begin
      bit carr = comp && (k >= c * SC + 1) && (k <= c * SC + SC - 1);
      bit seen = comp && (k >= c * SC + 2);
      if (seen || carr || (k > o * SC)) begin
        idx = k + 1;
        return;
      end
      if (k == o * SC) begin
        okk = 1'b1;
        idx = o * SC + SC;
        return;
      end
    end
  endfunction

  task automatic reply_case(input int prio, input bit comp, input int c, input int r);
    int o;
    bit okk;
    int idx;
    o = NP - 1 - prio;
    predict(o, comp, c, r, okk, idx);
    node_prio    = PW'(prio);
    bus_rx_end   = 1'b1;
    bus_rx_query = 1'b1;
    step();
    bus_rx_end   = 1'b0;
    bus_rx_query = 1'b0;
    for (int j = 0; j <= WLEN; j++) begin
      bit etx;
      etx = okk && (j >= o * SC + 1) && (j <= o * SC + SC - 1);
      chk(okk ? "R2 tx slot" : "R4 no tx", bus_tx_en, etx);
      chk("R3 ok pulse", rep_ok, okk && (j == idx));
      chk((r > o * SC) ? "R5 late reject" : "R4 blocked reject", rep_rej, !okk && (j == idx));
      if (j == idx) rep_req = 1'b0;
      if (j == r) rep_req = 1'b1;
      bus_carrier = comp && (j >= c * SC + 1) && (j <= c * SC + SC - 1);
      step();
    end
    bus_carrier = 1'b0;
    rep_req     = 1'b0;
    step();
  endtask

  // Own query; lag = negedges with tx still low before sending starts.
  task automatic own_query(input int lag, input bit with_car, input int cc, input bit probe);
    qry_req = 1'b1;
    for (int w = 0; w < lag; w++) begin
      step();
      bus_rx_end = 1'b0;
      chk("R9 guard holds", bus_tx_en, 1'b0);
    end
    step();
    bus_rx_end = 1'b0;
    for (int i = 0; i <= QC + WLEN; i++) begin
      int k;
      k = i - QC;
      chk("R7 query tx", bus_tx_en, i < QC);
      chk("R8 done", qry_done, i == QC + WLEN);
      if (i == QC + WLEN) begin
        chk("R8 hit", qry_hit, with_car);
        qry_req = 1'b0;
      end
      if (probe && i == QC + 2) begin
        chk("R7 own window reject", rep_rej, 1'b1);
        rep_req = 1'b0;
      end else begin
        chk("R7 no reject", rep_rej, 1'b0);
      end
      if (probe && i == QC + 1) rep_req = 1'b1;
      if (i < QC + WLEN) begin
        bus_carrier = with_car && (k >= cc * SC + 1) && (k <= cc * SC + SC - 1);
        step();
      end
    end
    bus_carrier = 1'b0;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);

    // R1 during and after reset
    repeat (4) step();
    chk("R1 tx", bus_tx_en, 1'b0);
    chk("R1 ok", rep_ok, 1'b0);
    chk("R1 rej", rep_rej, 1'b0);
    arst_n = 1'b1;
    repeat (4) step();
    chk("R1 tx", bus_tx_en, 1'b0);
    chk("R1 done", qry_done, 1'b0);

    // R6 request outside any window
    rep_req = 1'b1;
    step();
    chk("R6 reject", rep_rej, 1'b1);
    chk("R6 no tx", bus_tx_en, 1'b0);
    rep_req = 1'b0;
    step();
    chk("R6 single pulse", rep_rej, 1'b0);
    chk("R10 no ok", rep_ok, 1'b0);

    // Directed corner cases
    reply_case(NP - 1, 1'b0, 0, 0);
    reply_case(0, 1'b0, 0, 0);
    reply_case(0, 1'b1, 0, 0);
    reply_case(0, 1'b1, 2, 3);
    reply_case(1, 1'b0, 0, 2 * SC + 1);
    reply_case(NP - 1, 1'b0, 0, WLEN - 1);

    // Constrained random replies
    for (int n = 0; n < 40; n++) begin
      int prio;
      int o;
      bit comp;
      int c;
      int r;
      prio = int'($urandom_range(0, NP - 1));
      o    = NP - 1 - prio;
      comp = (o > 0) && ($urandom_range(0, 1) == 1);
      c    = (o > 0) ? int'($urandom_range(0, o - 1)) : 0;
      r    = ($urandom_range(0, 1) == 1) ? 0 : int'($urandom_range(0, WLEN - 1));
      reply_case(prio, comp, c, r);
      repeat (int'($urandom_range(0, 3))) step();
    end

    // Release the guard, then own queries (R7, R8, R9)
    bus_rx_end = 1'b1;
    step();
    bus_rx_end = 1'b0;
    step();
    own_query(0, 1'b0, 0, 1'b1);
    own_query(GC - WLEN, 1'b1, 1, 1'b0);
    step();
    bus_rx_end = 1'b1;
    own_query(1, 1'b0, 0, 1'b0);
    step();
    chk("R8 done single", qry_done, 1'b0);

    finish_run();
  end
endmodule